// File: doc/BRIEF.md
# Byte-Serial SPI Master Burst Engine

This block is an SPI master that clocks 8-bit words out of a transmit queue and into a receive queue under the control of a small register port. Software programs the clock mode, the bit order, the chip-select handling, a total burst length and the number of leading bytes that come from the transmit queue. Software then sets the start bit. The engine shifts the whole burst without further help and raises a completion flag at the end. After the real transmit bytes run out, the engine sends 0x00 filler bytes, so a read-only transaction needs no dummy data in the queue. A discard mode keeps the receive queue untouched during write-only bursts.

Both queues face the rest of the chip as valid/ready streams. A transmit byte is accepted on a clock where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low only while the transmit queue is full. A receive byte is taken on a clock where `rx_valid` and `rx_ready` are both high. `rx_data` holds its value while `rx_ready` stays low. The engine never throttles the receive side. A byte that arrives at a full receive queue is lost and is reported instead. The bit rate comes from `sclk_tick`, a one-cycle pulse made by an external divider. Each tick moves SCK by one edge.

Register port (word index on `reg_addr`, writes on `reg_wr`, reads combinational): 0 control, 1 burst length, 2 transmit count, 3 interrupt enable, 4 interrupt status.

Top module: `spi_burst_master`

## Requirements
- R1: After reset every register reads 0, SCK and all four chip-select lines are low, `irq` and `rx_valid` are low and `tx_ready` is high.
- R2: Control bit 1 sets the level of SCK between bytes. Control bit 0 picks the sampling edge: when clear, MISO is sampled on the first edge of each bit and MOSI changes on the second; when set, the other way round. Every byte takes 16 SCK edges, one per `sclk_tick` pulse.
- R3: With control bit 12 set, each byte is shifted least significant bit first in both directions. With it clear, each byte goes most significant bit first.
- R4: The burst register (bits 23:0) gives the number of bytes clocked. The transmit count register (bits 23:0) gives how many of them are popped from the transmit queue. Every later byte goes out as 0x00 and pops nothing.
- R5: When a transmit byte is due and the transmit queue is empty, SCK holds and the burst waits until a byte arrives.
- R6: With control bit 8 set, received bytes are dropped and the receive queue does not change.
- R7: A byte received with bit 8 clear while the receive queue (128 entries) is full is dropped, and status bit 8 is set.
- R8: Control bits 5:4 pick one of four chip-select lines. Bit 2 gives the idle level of every line, and the picked line takes the opposite level from the start bit until the clock after the last SCK edge. All other lines stay idle.
- R9: With control bit 6 set, the picked line is driven to control bit 7 and ignores both bit 2 and the burst state.
- R10: Writing control with bit 31 set while idle starts a burst. Bit 31 reads 1 until the last byte completes, and in that clock status bit 12 is set. A start with a burst length of 0 sets status bit 12 at once and clocks no byte.
- R11: Writing 1 to a status bit clears it, and a new event in the same clock wins. `irq` is high while any status bit has its enable bit (same position) set.
- R12: Control writes during a burst are ignored.
- R13: `tx_ready` is low only when the 128-entry transmit queue is full, and `rx_data` holds while `rx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit queue can accept |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Receive byte available |
| rx_ready | input | 1 | Receive byte taken |
| rx_data | output | 8 | Receive byte at queue head |
| sclk_tick | input | 1 | One-cycle pulse per SCK edge |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_line | output | 4 | Chip-select lines |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker checks these properties on every clock: SCK rests at the programmed polarity whenever no burst runs, no more than one chip-select line leaves its idle level, a burst ends only with the completion flag set, SCK holds while the engine waits on an empty transmit queue, no receive byte appears in discard mode, and the overflow flag rises only against a full receive queue. The bench scenarios with a behavioural slave show the rest: the bytes in both directions under each clock mode and bit order, the filler bytes and the untouched queue entry they leave behind, the count of 128 kept bytes after an overflow, the chip-select levels, the ignored mid-burst writes and the interrupt clearing.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  // control field positions (software decodes these)
  localparam int CTRL_CPHA    = 0;
  localparam int CTRL_CPOL    = 1;
  localparam int CTRL_CSIDLE  = 2;
  localparam int CTRL_CSSEL   = 4;
  localparam int CTRL_CSMAN   = 6;
  localparam int CTRL_CSLVL   = 7;
  localparam int CTRL_DISCARD = 8;
  localparam int CTRL_LSB     = 12;
  localparam int CTRL_GO      = 31;
  localparam logic [30:0] CTRL_MASK = 31'h0000_11F7;

  localparam int EV_OVF  = 8;
  localparam int EV_DONE = 12;
  localparam logic [31:0] EV_MASK = 32'h0000_1100;

  localparam int NUM_CS = 4;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_BURST = 3'd1;
  localparam logic [2:0] A_TXCNT = 3'd2;
  localparam logic [2:0] A_IEN   = 3'd3;
  localparam logic [2:0] A_ISTAT = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_RUN} eng_state_e;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 128   // power of two
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  wire push_ok = push && !full;
  wire pop_ok  = pop && !empty;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_byte,
  input  logic            tick,
  input  logic            cpha,
  input  logic            lsb_first,
  input  logic            miso,
  output logic            mosi,
  output logic            phase,
  output logic            byte_done,
  output logic [BITS-1:0] rx_byte
);
  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  logic [EW-1:0]   edge_q;
  logic            active_q;
  logic [BITS-1:0] tx_sh, rx_sh, rx_next;

  wire step     = active_q && tick;
  wire leading  = !edge_q[0];
  wire sample   = cpha ? !leading : leading;
  wire advance  = cpha ? (leading && edge_q != '0) : (!leading && edge_q != LAST_EDGE);

  always_comb begin
    rx_next = rx_sh;
    if (sample) rx_next = lsb_first ? {miso, rx_sh[BITS-1:1]} : {rx_sh[BITS-2:0], miso};
  end

  assign mosi      = lsb_first ? tx_sh[0] : tx_sh[BITS-1];
  assign byte_done = step && (edge_q == LAST_EDGE);
  assign rx_byte   = rx_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q   <= '0;
      active_q <= 1'b0;
      phase    <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else if (load) begin
      tx_sh    <= load_byte;
      edge_q   <= '0;
      active_q <= 1'b1;
      phase    <= 1'b0;
    end else if (step) begin
      edge_q <= edge_q + 1'b1;
      phase  <= ~phase;
      rx_sh  <= rx_next;
      if (advance) tx_sh <= lsb_first ? {1'b0, tx_sh[BITS-1:1]} : {tx_sh[BITS-2:0], 1'b0};
      if (edge_q == LAST_EDGE) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 128,
  parameter int CNT_W      = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  input  logic              sclk_tick,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_line,
  output logic              irq
);
  localparam int PADW = 32 - CNT_W;

  logic [30:0]      ctrl_q;
  logic [CNT_W-1:0] burst_q, txcnt_q, burst_left, tx_left;
  logic [31:0]      ien_q, istat_q;
  eng_state_e       state;

  logic              txq_full, txq_empty, txq_pop, rxq_full, rxq_empty, rxq_push;
  logic [DATA_W-1:0] txq_dout, load_byte, rx_byte;
  logic              core_load, core_done, phase;

  wire busy    = (state != ST_IDLE);
  wire cpol    = ctrl_q[CTRL_CPOL];
  wire cs_idle = ctrl_q[CTRL_CSIDLE];
  wire discard = ctrl_q[CTRL_DISCARD];

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL && !busy;
  wire start   = wr_ctrl && reg_wdata[CTRL_GO];

  // fetch stage: real byte, filler, or wait for the queue
  wire need_tx    = (tx_left != '0);
  wire fetch_wait = (state == ST_FETCH) && need_tx && txq_empty;
  assign core_load = (state == ST_FETCH) && !fetch_wait;
  assign txq_pop   = core_load && need_tx;
  assign load_byte = need_tx ? txq_dout : '0;

  wire last_byte = (burst_left == CNT_W'(1));
  wire fin       = (state == ST_RUN) && core_done && last_byte;
  assign rxq_push = core_done && !discard;

  logic [31:0] ev_set, ev_clr;
  always_comb begin
    ev_set = '0;
    ev_set[EV_DONE] = fin || (start && burst_q == '0);
    ev_set[EV_OVF]  = rxq_push && rxq_full;
    ev_clr = (reg_wr && reg_addr == A_ISTAT) ? reg_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      burst_q    <= '0;
      txcnt_q    <= '0;
      ien_q      <= '0;
      istat_q    <= '0;
      state      <= ST_IDLE;
      burst_left <= '0;
      tx_left    <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata[30:0] & CTRL_MASK;
      if (reg_wr && reg_addr == A_BURST) burst_q <= reg_wdata[CNT_W-1:0];
      if (reg_wr && reg_addr == A_TXCNT) txcnt_q <= reg_wdata[CNT_W-1:0];
      if (reg_wr && reg_addr == A_IEN)   ien_q   <= reg_wdata & EV_MASK;
      istat_q <= ((istat_q & ~ev_clr) | ev_set) & EV_MASK;

      case (state)
        ST_IDLE: if (start && burst_q != '0) begin
          burst_left <= burst_q;
          tx_left    <= txcnt_q;
          state      <= ST_FETCH;
        end
        ST_FETCH: if (core_load) begin
          if (need_tx) tx_left <= tx_left - 1'b1;
          state <= ST_RUN;
        end
        default: if (core_done) begin
          burst_left <= burst_left - 1'b1;
          state      <= last_byte ? ST_IDLE : ST_FETCH;
        end
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {busy, ctrl_q};
      A_BURST: reg_rdata = {{PADW{1'b0}}, burst_q};
      A_TXCNT: reg_rdata = {{PADW{1'b0}}, txcnt_q};
      A_IEN:   reg_rdata = ien_q;
      A_ISTAT: reg_rdata = istat_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq  = |(ien_q & istat_q);
  assign sclk = cpol ^ phase;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    wire picked = (ctrl_q[CTRL_CSSEL +: 2] == 2'(i));
    assign cs_line[i] = !picked              ? cs_idle :
                        ctrl_q[CTRL_CSMAN]   ? ctrl_q[CTRL_CSLVL] :
                        busy                 ? !cs_idle : cs_idle;
  end

  spi_byte_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_valid), .din(tx_data), .pop(txq_pop),
    .dout(txq_dout), .full(txq_full), .empty(txq_empty));
  assign tx_ready = !txq_full;

  spi_byte_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rxq_push), .din(rx_byte), .pop(rx_ready),
    .dout(rx_data), .full(rxq_full), .empty(rxq_empty));
  assign rx_valid = !rxq_empty;

  spi_shift_core #(.BITS(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(core_load), .load_byte(load_byte),
    .tick(sclk_tick), .cpha(ctrl_q[CTRL_CPHA]), .lsb_first(ctrl_q[CTRL_LSB]),
    .miso(miso), .mosi(mosi), .phase(phase), .byte_done(core_done), .rx_byte(rx_byte));
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           sclk,
  input logic           cpol,
  input logic [NCS-1:0] cs_line,
  input logic           cs_idle,
  input logic           discard,
  input logic           rx_valid,
  input logic           rx_full,
  input logic           ovf_flag,
  input logic           done_flag,
  input logic           fetch_wait
);
  // R2: SCK rests at the programmed polarity outside a burst
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cpol);

  // R8: at most one line leaves the idle level
  p_cs_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_line ^ {NCS{cs_idle}}) <= 1);

  // R10: a burst ends only with the completion flag raised
  p_done_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);

  // R5: SCK holds while waiting on an empty transmit queue
  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_wait |=> $stable(sclk) && busy);

  // R6: nothing enters the receive queue in discard mode
  p_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && discard) |=> !$rose(rx_valid));

  // R7: overflow flag rises only against a full receive queue
  p_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(rx_full));
endmodule

bind spi_burst_master spi_burst_master_chk #(.NCS(spi_burst_pkg::NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(sclk), .cpol(cpol),
  .cs_line(cs_line), .cs_idle(cs_idle), .discard(discard), .rx_valid(rx_valid),
  .rx_full(rxq_full), .ovf_flag(istat_q[spi_burst_pkg::EV_OVF]),
  .done_flag(istat_q[spi_burst_pkg::EV_DONE]), .fetch_wait(fetch_wait));

// File: tb/spi_burst_master_test.sv
module spi_burst_master_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, reg_wr, tx_valid, rx_ready, sclk_tick, miso;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        tx_ready, rx_valid, sclk, mosi, irq;
  logic [7:0]  tx_data, rx_data;
  logic [3:0]  cs_line;

  spi_burst_master uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .sclk_tick(sclk_tick),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_line(cs_line), .irq(irq));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0;

  // slave model state
  logic [7:0] sl_tx [16];
  logic [7:0] sl_got [256];
  logic [7:0] sl_sh;
  int sl_n, sl_sc, sl_oc, sl_idx;
  logic sl_last, b_cpha, b_cpol, b_lsb;

  function automatic logic slave_bit();
    logic [7:0] cur;
    cur = sl_tx[sl_idx % 16];
    return b_lsb ? cur[sl_oc] : cur[7 - sl_oc];
  endfunction

  initial begin
    sclk_tick = 1'b0;
    forever begin
      @(negedge clk);
      sclk_tick = ~sclk_tick;
    end
  end

  initial begin
    sl_n = 0; sl_sc = 0; sl_oc = 0; sl_idx = 0; sl_sh = '0;
    sl_last = 1'b0; b_cpha = 1'b0; b_cpol = 1'b0; b_lsb = 1'b0; miso = 1'b0;
    for (int i = 0; i < 16; i++) sl_tx[i] = 8'(i * 29 + 7);
    forever begin
      @(negedge clk);
      if (rst_n && sclk !== sl_last) begin
        logic lead;
        lead = (sclk != b_cpol);
        if (b_cpha ? !lead : lead) begin
          sl_sh = b_lsb ? {mosi, sl_sh[7:1]} : {sl_sh[6:0], mosi};
          sl_sc++;
          if (sl_sc == 8) begin
            sl_got[sl_n % 256] = sl_sh;
            sl_n++; sl_sc = 0; sl_oc = 0; sl_idx++;
          end
        end else if (sl_sc != 0) sl_oc++;
        sl_last = sclk;
      end
      miso = slave_bit();
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop(output logic [7:0] b);
    int n = 0;
    while (!rx_valid && n < 5000) begin @(negedge clk); n++; end
    b = rx_data;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (rx_valid) begin rx_ready = 1'b1; @(negedge clk); end
    rx_ready = 1'b0;
  endtask

  task automatic cfg(input logic [31:0] c, input int burst, input int txn);
    wr(3'd1, 32'(burst));
    wr(3'd2, 32'(txn));
    wr(3'd0, c);
    wr(3'd4, 32'hFFFF_FFFF);
    b_cpha = c[0]; b_cpol = c[1]; b_lsb = c[12];
    sl_n = 0; sl_sc = 0; sl_oc = 0; sl_idx = 0; sl_last = sclk;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    int n = 0;
    rd(3'd4, v);
    while (!v[12] && n < 20000) begin @(negedge clk); rd(3'd4, v); n++; end
    chk("R10 completion flag", 32'(v[12]), 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 cs lines", 32'(cs_line), 32'h0);
    chk("R1 sclk", 32'(sclk), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 rx_valid", 32'(rx_valid), 32'd0);
    chk("R1 R13 tx_ready", 32'(tx_ready), 32'd1);
    rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
    rd(3'd1, v); chk("R1 burst", v, 32'h0);
    rd(3'd4, v); chk("R1 status", v, 32'h0);
  endtask

  task automatic t_mode0();
    logic [7:0] b;
    cfg(32'h0, 3, 3);
    sl_tx[0] = 8'h5A; sl_tx[1] = 8'hC3; sl_tx[2] = 8'hF0;
    push(8'hA5); push(8'h3C); push(8'h0F);
    wr(3'd0, 32'h8000_0000);
    wait_done();
    chk("R2 mode0 bytes seen", 32'(sl_n), 32'd3);
    chk("R2 mode0 mosi b0", 32'(sl_got[0]), 32'hA5);
    chk("R2 mode0 mosi b1", 32'(sl_got[1]), 32'h3C);
    chk("R2 mode0 mosi b2", 32'(sl_got[2]), 32'h0F);
    repeat (5) @(negedge clk);
    chk("R13 rx_data held", 32'(rx_data), 32'h5A);
    pop(b); chk("R2 mode0 miso b0", 32'(b), 32'h5A);
    pop(b); chk("R2 mode0 miso b1", 32'(b), 32'hC3);
    pop(b); chk("R2 mode0 miso b2", 32'(b), 32'hF0);
  endtask

  task automatic t_mode3_lsb();
    logic [7:0] b;
    cfg(32'h1003, 2, 2);
    chk("R2 sclk idle high", 32'(sclk), 32'd1);
    sl_tx[0] = 8'h18; sl_tx[1] = 8'h24;
    push(8'h01); push(8'hE7);
    wr(3'd0, 32'h8000_1003);
    wait_done();
    chk("R3 lsb mosi b0", 32'(sl_got[0]), 32'h01);
    chk("R3 lsb mosi b1", 32'(sl_got[1]), 32'hE7);
    pop(b); chk("R3 lsb miso b0", 32'(b), 32'h18);
    pop(b); chk("R3 lsb miso b1", 32'(b), 32'h24);
    chk("R2 sclk back high", 32'(sclk), 32'd1);
  endtask

  task automatic t_filler();
    push(8'h11); push(8'h22); push(8'h33);
    cfg(32'h0, 4, 2);
    wr(3'd0, 32'h8000_0000);
    wait_done();
    chk("R4 bytes clocked", 32'(sl_n), 32'd4);
    chk("R4 real b0", 32'(sl_got[0]), 32'h11);
    chk("R4 real b1", 32'(sl_got[1]), 32'h22);
    chk("R4 filler b2", 32'(sl_got[2]), 32'h00);
    chk("R4 filler b3", 32'(sl_got[3]), 32'h00);
    drain();
    cfg(32'h0, 1, 1);
    wr(3'd0, 32'h8000_0000);
    wait_done();
    chk("R4 filler popped nothing", 32'(sl_got[0]), 32'h33);
    drain();
  endtask

  task automatic t_discard();
    logic [31:0] v;
    cfg(32'h100, 2, 2);
    push(8'h44); push(8'h55);
    wr(3'd0, 32'h8000_0100);
    wait_done();
    @(negedge clk);
    chk("R6 rx queue untouched", 32'(rx_valid), 32'd0);
    chk("R6 tx still sent", 32'(sl_got[1]), 32'h55);
    rd(3'd4, v); chk("R6 no overflow", 32'(v[8]), 32'd0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    logic [7:0] b, first;
    int kept = 0;
    wr(3'd3, 32'h100);
    cfg(32'h0, 130, 0);
    for (int i = 0; i < 16; i++) sl_tx[i] = 8'(i * 17 + 3);
    wr(3'd0, 32'h8000_0000);
    wait_done();
    rd(3'd4, v); chk("R7 overflow flag", 32'(v[8]), 32'd1);
    chk("R11 irq on overflow", 32'(irq), 32'd1);
    chk("R13 tx_ready idle", 32'(tx_ready), 32'd1);
    pop(first); kept = 1;
    chk("R7 first kept byte", 32'(first), 32'h03);
    @(negedge clk);
    while (rx_valid) begin pop(b); kept++; end
    chk("R7 kept count", 32'(kept), 32'd128);
    wr(3'd4, 32'h100);
    rd(3'd4, v); chk("R11 w1c overflow only", v, 32'h1000);
    chk("R11 irq cleared", 32'(irq), 32'd0);
    wr(3'd3, 32'h0);
  endtask

  task automatic t_cs_auto();
    logic [31:0] v;
    cfg(32'h24, 3, 0);
    chk("R8 idle high lines", 32'(cs_line), 32'hF);
    wr(3'd0, 32'h8000_0024);
    repeat (6) @(negedge clk);
    chk("R8 picked line active", 32'(cs_line), 32'hB);
    wr(3'd0, 32'h0000_0010);
    chk("R12 write ignored cs", 32'(cs_line), 32'hB);
    wait_done();
    chk("R8 released", 32'(cs_line), 32'hF);
    rd(3'd0, v); chk("R12 ctrl unchanged", v, 32'h24);
    drain();
    cfg(32'h10, 1, 0);
    wr(3'd0, 32'h8000_0010);
    repeat (4) @(negedge clk);
    chk("R8 low-idle select", 32'(cs_line), 32'h2);
    wait_done();
    chk("R8 low-idle released", 32'(cs_line), 32'h0);
    drain();
  endtask

  task automatic t_cs_manual();
    wr(3'd0, 32'hF0);
    chk("R9 manual high", 32'(cs_line), 32'h8);
    wr(3'd0, 32'h70);
    chk("R9 manual low", 32'(cs_line), 32'h0);
    wr(3'd0, 32'h74);
    chk("R9 ignores idle level", 32'(cs_line), 32'h7);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_go_flag();
    logic [31:0] v;
    cfg(32'h0, 3, 0);
    wr(3'd0, 32'h8000_0000);
    rd(3'd0, v); chk("R10 start reads busy", 32'(v[31]), 32'd1);
    rd(3'd4, v); chk("R10 no early done", 32'(v[12]), 32'd0);
    wait_done();
    rd(3'd0, v); chk("R10 start cleared", 32'(v[31]), 32'd0);
    drain();
    cfg(32'h0, 0, 0);
    wr(3'd0, 32'h8000_0000);
    rd(3'd4, v); chk("R10 zero burst done", 32'(v[12]), 32'd1);
    rd(3'd0, v); chk("R10 zero burst idle", 32'(v[31]), 32'd0);
    repeat (40) @(negedge clk);
    chk("R10 zero burst no bytes", 32'(sl_n), 32'd0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(3'd3, 32'h1000);
    cfg(32'h100, 1, 0);
    chk("R11 irq low before", 32'(irq), 32'd0);
    wr(3'd0, 32'h8000_0100);
    wait_done();
    chk("R11 irq on done", 32'(irq), 32'd1);
    wr(3'd4, 32'h1000);
    rd(3'd4, v); chk("R11 w1c done", v, 32'h0);
    chk("R11 irq dropped", 32'(irq), 32'd0);
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h8000_0100);
    wait_done();
    chk("R11 masked irq", 32'(irq), 32'd0);
  endtask

  task automatic t_stall();
    logic [31:0] v;
    cfg(32'h0, 2, 2);
    push(8'h66);
    wr(3'd0, 32'h8000_0000);
    repeat (200) @(negedge clk);
    rd(3'd0, v); chk("R5 still busy", 32'(v[31]), 32'd1);
    rd(3'd4, v); chk("R5 not done", 32'(v[12]), 32'd0);
    chk("R5 one byte sent", 32'(sl_n), 32'd1);
    push(8'h77);
    wait_done();
    chk("R5 resumed byte", 32'(sl_got[1]), 32'h77);
    drain();
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    tx_valid = 1'b0; tx_data = '0; rx_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_mode3_lsb();
    t_filler();
    t_discard();
    t_overflow();
    t_cs_auto();
    t_cs_manual();
    t_go_flag();
    t_irq();
    t_stall();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule